// File: doc/BRIEF.md
# Subcarrier Real-Time Control Receiver

This block sits between an external video decoder and the chroma subcarrier oscillator of a video encoder. The decoder sends a serial control stream, one bit every two pixel clocks. Each frame carries a new subcarrier frequency word. The receiver pulls the 22-bit frequency field out of each 67-bit frame and holds it until the next video line boundary. At that boundary it presents the word to the oscillator together with a one-clock valid pulse, so the oscillator changes frequency one line at a time and never in the middle of a line.

The same serial pin has a second use, chosen by a 2-bit mode input. In phase-reset mode, a rising edge on the pin arms a request. At the next field-start strobe the block issues a one-clock pulse that tells the oscillator to return its phase to the field-0 state. While real-time tracking is in use, the locally programmed frequency registers of the oscillator are expected to hold zero. The oscillator itself and all register access sit outside this block.

Top module: `sc_rtc_rx`

## Requirements
- R1: While reset is active and right after it is released, `freq_word` is zero and both `freq_valid` and `phase_rst` are low.
- R2: In tracking mode (`mode` = 2'b10), a frame begins when `ser_in` is sampled high after being sampled low while the receiver is idle. That start marker lasts two clocks. It is followed by 67 data bits of two clocks each. Each data bit is sampled on the second clock of its period, and data bit 0 comes first.
- R3: Data bits 0 to 21 form `freq_word`, with data bit 0 as the LSB. Data bits 22 to 66 have no effect on `freq_word`.
- R4: A received word reaches `freq_word` only at the first `line_start` sampled after the frame's last bit has been sampled. `freq_word` and `freq_valid` change on the clock edge that samples that `line_start`. At all other times `freq_word` holds its value.
- R5: `freq_valid` is high for exactly one clock per received frame. A `line_start` that arrives with no complete frame pending gives no pulse and leaves `freq_word` unchanged.
- R6: When `mode` is anything other than 2'b10, the serial input starts no frame. It produces no `freq_valid` pulse and leaves `freq_word` unchanged. Leaving tracking mode drops any pending word.
- R7: In phase-reset mode (`mode` = 2'b01), a rising edge of `ser_in` arms a request. The next `field_start` then drives `phase_rst` high for exactly one clock, starting at the edge that samples `field_start`. A `field_start` that arrives with nothing armed gives no pulse.
- R8: A rising edge that arrives while a request is already armed does not create a second pulse. When a `field_start` meets an armed request, an edge in that same cycle is ignored.
- R9: `phase_rst` is never asserted when `mode` is not 2'b01. Leaving phase-reset mode discards an armed request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_in | input | 1 | Serial control stream / phase-reset trigger |
| mode | input | 2 | 2'b10 frequency tracking, 2'b01 phase reset, other values off |
| line_start | input | 1 | One-clock strobe at each video line boundary |
| field_start | input | 1 | One-clock strobe at each field boundary |
| freq_word | output | 22 | Subcarrier frequency word last applied |
| freq_valid | output | 1 | One-clock pulse when `freq_word` takes a new value |
| phase_rst | output | 1 | One-clock subcarrier phase reset request |

## Verification
Random 67-bit frames check that the word is assembled in the right bit order and from the right field. Directed frames check the extremes. One frame has a zero word under all-ones upper bits, and the other is the reverse; a decoder that read the wrong window or shifted in the wrong direction would fail on these. Checks before the line strobe, and extra line strobes after it, separate a correct line-boundary hand-off from an early or repeated one. In phase-reset mode, a random stream of edges and field strobes runs against a small arm/fire model, which exposes lost or duplicated resets. Directed cases cover mode changes and inactive modes.

// File: rtl/sc_rtc_pkg.sv
package sc_rtc_pkg;

  typedef enum logic [1:0] {
    MODE_OFF   = 2'b00,
    MODE_PHRST = 2'b01,
    MODE_TRACK = 2'b10,
    MODE_SPARE = 2'b11
  } sc_mode_e;

  typedef enum logic {
    RX_IDLE = 1'b0,
    RX_BUSY = 1'b1
  } rx_state_e;

endpackage

// File: rtl/sc_rtc_edge.sv
module sc_rtc_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= din;
  end

  assign rise = din & ~prev_q;
endmodule

// File: rtl/sc_rtc_deser.sv
module sc_rtc_deser
  import sc_rtc_pkg::*;
#(
  parameter int FRAME_BITS   = 67,
  parameter int WORD_BITS    = 22,
  parameter int CLKS_PER_BIT = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 enable,
  input  logic                 start,
  input  logic                 din,
  output logic [WORD_BITS-1:0] word_o,
  output logic                 done_o
);
  localparam int POS_W = $clog2(FRAME_BITS + 1);
  localparam int PH_W  = (CLKS_PER_BIT > 2) ? $clog2(CLKS_PER_BIT) : 1;
  localparam logic [PH_W-1:0]  PH_LAST  = PH_W'(CLKS_PER_BIT - 1);
  localparam logic [POS_W-1:0] POS_LAST = POS_W'(FRAME_BITS);

  rx_state_e            state_q, state_d;
  logic [PH_W-1:0]      phase_q, phase_d;
  logic [POS_W-1:0]     pos_q, pos_d;
  logic [WORD_BITS-1:0] cap_q, cap_d;
  logic                 sample_en;
  logic [WORD_BITS-1:0] bit_sel;

  assign sample_en = (state_q == RX_BUSY) && (phase_q == PH_LAST) && (pos_q != '0);

  for (genvar i = 0; i < WORD_BITS; i++) begin : g_sel
    assign bit_sel[i] = sample_en && (pos_q == POS_W'(i + 1));
  end

  always_comb begin
    state_d = state_q;
    phase_d = phase_q;
    pos_d   = pos_q;
    done_o  = 1'b0;
    for (int i = 0; i < WORD_BITS; i++) begin
      cap_d[i] = bit_sel[i] ? din : cap_q[i];
    end
    if (!enable) begin
      state_d = RX_IDLE;
    end else if (state_q == RX_IDLE) begin
      if (start) begin
        state_d = RX_BUSY;
        phase_d = PH_W'(1);
        pos_d   = '0;
      end
    end else begin
      if (phase_q == PH_LAST) begin
        phase_d = '0;
        pos_d   = pos_q + 1'b1;
        if (sample_en && pos_q == POS_LAST) begin
          done_o  = 1'b1;
          state_d = RX_IDLE;
        end
      end else begin
        phase_d = phase_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_IDLE;
      phase_q <= '0;
      pos_q   <= '0;
      cap_q   <= '0;
    end else begin
      state_q <= state_d;
      phase_q <= phase_d;
      pos_q   <= pos_d;
      cap_q   <= cap_d;
    end
  end

  assign word_o = cap_d;
endmodule

// File: rtl/sc_rtc_apply.sv
module sc_rtc_apply #(
  parameter int WORD_BITS = 22
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 enable,
  input  logic                 frame_done,
  input  logic [WORD_BITS-1:0] frame_word,
  input  logic                 line_start,
  output logic [WORD_BITS-1:0] word_o,
  output logic                 valid_o
);
  logic                 pend_q, pend_d;
  logic [WORD_BITS-1:0] hold_q, hold_d;
  logic [WORD_BITS-1:0] word_q, word_d;
  logic                 valid_q, valid_d;

  always_comb begin
    pend_d  = pend_q;
    hold_d  = hold_q;
    word_d  = word_q;
    valid_d = 1'b0;
    if (!enable) begin
      pend_d = 1'b0;
    end else begin
      if (line_start && pend_q) begin
        word_d  = hold_q;
        valid_d = 1'b1;
        pend_d  = 1'b0;
      end
      if (frame_done) begin
        pend_d = 1'b1;
        hold_d = frame_word;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      hold_q  <= '0;
      word_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      pend_q  <= pend_d;
      hold_q  <= hold_d;
      word_q  <= word_d;
      valid_q <= valid_d;
    end
  end

  assign word_o  = word_q;
  assign valid_o = valid_q;
endmodule

// File: rtl/sc_rtc_phase.sv
module sc_rtc_phase (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic rise,
  input  logic field_start,
  output logic pulse_o
);
  logic armed_q, armed_d;
  logic pulse_q, pulse_d;

  always_comb begin
    armed_d = armed_q;
    pulse_d = 1'b0;
    if (!enable) begin
      armed_d = 1'b0;
    end else if (field_start && armed_q) begin
      pulse_d = 1'b1;
      armed_d = 1'b0;
    end else if (rise) begin
      armed_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      armed_q <= armed_d;
      pulse_q <= pulse_d;
    end
  end

  assign pulse_o = pulse_q;
endmodule

// File: rtl/sc_rtc_rx.sv
module sc_rtc_rx
  import sc_rtc_pkg::*;
#(
  parameter int FRAME_BITS   = 67,
  parameter int WORD_BITS    = 22,
  parameter int CLKS_PER_BIT = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ser_in,
  input  logic [1:0]           mode,
  input  logic                 line_start,
  input  logic                 field_start,
  output logic [WORD_BITS-1:0] freq_word,
  output logic                 freq_valid,
  output logic                 phase_rst
);
  sc_mode_e             mode_e;
  logic                 track_en;
  logic                 phrst_en;
  logic                 rise;
  logic                 frame_done;
  logic [WORD_BITS-1:0] frame_word;

  assign mode_e   = sc_mode_e'(mode);
  assign track_en = (mode_e == MODE_TRACK);
  assign phrst_en = (mode_e == MODE_PHRST);

  sc_rtc_edge i_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (ser_in),
    .rise (rise)
  );

  sc_rtc_deser #(
    .FRAME_BITS  (FRAME_BITS),
    .WORD_BITS   (WORD_BITS),
    .CLKS_PER_BIT(CLKS_PER_BIT)
  ) i_deser (
    .clk   (clk),
    .rst_n (rst_n),
    .enable(track_en),
    .start (rise),
    .din   (ser_in),
    .word_o(frame_word),
    .done_o(frame_done)
  );

  sc_rtc_apply #(
    .WORD_BITS(WORD_BITS)
  ) i_apply (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (track_en),
    .frame_done(frame_done),
    .frame_word(frame_word),
    .line_start(line_start),
    .word_o    (freq_word),
    .valid_o   (freq_valid)
  );

  sc_rtc_phase i_phase (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (phrst_en),
    .rise       (rise),
    .field_start(field_start),
    .pulse_o    (phase_rst)
  );
endmodule

// File: rtl/sc_rtc_chk.sv
module sc_rtc_chk #(
  parameter int WORD_BITS = 22
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [1:0]           mode,
  input logic                 line_start,
  input logic                 field_start,
  input logic [WORD_BITS-1:0] freq_word,
  input logic                 freq_valid,
  input logic                 phase_rst
);
  // R1: outputs idle while reset is held
  always_comb begin
    if (!rst_n) begin
      a_r1_reset_idle: assert (freq_valid == 1'b0 && phase_rst == 1'b0);
    end
  end

  a_r4_word_held: assert property (@(posedge clk) disable iff (!rst_n)
    !freq_valid |-> $stable(freq_word));

  a_r4_valid_on_line: assert property (@(posedge clk) disable iff (!rst_n)
    freq_valid |-> $past(line_start));

  a_r5_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
    freq_valid |=> !freq_valid);

  a_r6_valid_in_track: assert property (@(posedge clk) disable iff (!rst_n)
    freq_valid |-> ($past(mode) == 2'b10));

  a_r7_pulse_on_field: assert property (@(posedge clk) disable iff (!rst_n)
    phase_rst |-> $past(field_start));

  a_r7_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    phase_rst |=> !phase_rst);

  a_r9_pulse_in_phrst: assert property (@(posedge clk) disable iff (!rst_n)
    phase_rst |-> ($past(mode) == 2'b01));
endmodule

bind sc_rtc_rx sc_rtc_chk #(.WORD_BITS(WORD_BITS)) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mode       (mode),
  .line_start (line_start),
  .field_start(field_start),
  .freq_word  (freq_word),
  .freq_valid (freq_valid),
  .phase_rst  (phase_rst)
);

// File: tb/test_sc_rtc_rx.sv
module test_sc_rtc_rx;
  localparam int CLK_PERIOD = 10;
  localparam int FB = 67;
  localparam int WB = 22;

  logic          clk;
  logic          rst_n;
  logic          ser_in;
  logic [1:0]    mode;
  logic          line_start;
  logic          field_start;
  logic [WB-1:0] freq_word;
  logic          freq_valid;
  logic          phase_rst;

  int n_checks;
  int n_errs;
  logic [WB-1:0] cur_word;

  sc_rtc_rx i_sc_rtc_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .ser_in     (ser_in),
    .mode       (mode),
    .line_start (line_start),
    .field_start(field_start),
    .freq_word  (freq_word),
    .freq_valid (freq_valid),
    .phase_rst  (phase_rst)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [WB-1:0] exp_word(input logic [FB-1:0] fr);
    return fr[WB-1:0];
  endfunction

  function automatic logic [FB-1:0] rand_frame();
    return {$urandom, $urandom, $urandom};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  endtask

  task automatic send_frame(input logic [FB-1:0] fr);
    ser_in = 1'b1; tick(); tick();
    for (int k = 0; k < FB; k++) begin
      ser_in = fr[k]; tick(); tick();
    end
    ser_in = 1'b0; tick(); tick();
  endtask

  task automatic line_and_check(input bit exp_v, input logic [WB-1:0] exp_w, input string req);
    line_start = 1'b1; tick(); line_start = 1'b0;
    check(freq_valid == exp_v, req, 32'(freq_valid), 32'(exp_v));
    check(freq_word == exp_w, req, 32'(freq_word), 32'(exp_w));
    tick();
    check(freq_valid == 1'b0, req, 32'(freq_valid), 32'd0);
  endtask

  task automatic field_and_check(input bit exp_p, input string req);
    field_start = 1'b1; tick(); field_start = 1'b0;
    check(phase_rst == exp_p, req, 32'(phase_rst), 32'(exp_p));
    tick();
    check(phase_rst == 1'b0, req, 32'(phase_rst), 32'd0);
  endtask

  task automatic run_track(input logic [FB-1:0] fr);
    send_frame(fr);
    check(freq_valid == 1'b0 && freq_word == cur_word, "R4 no early apply", 32'(freq_word), 32'(cur_word));
    line_and_check(1'b1, exp_word(fr), "R2 R3 word applied at line");
    cur_word = exp_word(fr);
    line_and_check(1'b0, cur_word, "R5 no repeat pulse");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_errs++;
    $display("FAIL watchdog: actual=timeout expected=finished");
    finish_run();
  end

  initial begin
    n_checks = 0; n_errs = 0; cur_word = '0;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; ser_in = 1'b0; mode = 2'b00; line_start = 1'b0; field_start = 1'b0;
    tick(); tick();
    check(freq_word == '0 && !freq_valid && !phase_rst, "R1 reset state", 32'(freq_word), 32'd0);
    @(negedge clk); rst_n = 1'b1; tick();
    check(freq_word == '0 && !freq_valid && !phase_rst, "R1 after release", 32'(freq_word), 32'd0);

    mode = 2'b10; tick(); tick();
    line_and_check(1'b0, '0, "R5 line with nothing pending");

    // R3 directed extremes
    run_track({{(FB-WB){1'b0}}, {WB{1'b1}}});
    run_track({{(FB-WB){1'b1}}, {WB{1'b0}}});
    run_track({{(FB-WB){1'b0}}, 22'h2AAAAA});
    run_track({{(FB-WB){1'b1}}, 22'h000001});
    for (int n = 0; n < 6; n++) run_track(rand_frame());

    // R6 frames in other modes do nothing
    mode = 2'b00; tick();
    send_frame(rand_frame() | 67'h1);
    line_and_check(1'b0, cur_word, "R6 mode off ignored");
    mode = 2'b11; tick();
    send_frame(rand_frame() | 67'h2);
    line_and_check(1'b0, cur_word, "R6 spare mode ignored");
    // R6 pending dropped on mode exit
    mode = 2'b10; tick();
    send_frame({{(FB-WB){1'b0}}, ~cur_word});
    mode = 2'b00; tick(); mode = 2'b10; tick();
    line_and_check(1'b0, cur_word, "R6 pending dropped");

    // R9 phase reset never outside its mode
    mode = 2'b10; tick();
    field_and_check(1'b0, "R9 no pulse in track mode");

    // R7 arm and fire
    mode = 2'b01; tick();
    field_and_check(1'b0, "R7 field with nothing armed");
    ser_in = 1'b1; tick(); ser_in = 1'b0; tick();
    check(phase_rst == 1'b0, "R7 no pulse before field", 32'(phase_rst), 32'd0);
    field_and_check(1'b1, "R7 pulse at field start");
    field_and_check(1'b0, "R7 only once");

    // R8 second edge while armed
    ser_in = 1'b1; tick(); ser_in = 1'b0; tick();
    ser_in = 1'b1; tick(); ser_in = 1'b0; tick();
    field_and_check(1'b1, "R8 first fire");
    field_and_check(1'b0, "R8 no second reset");

    // R9 leaving mode discards arm
    ser_in = 1'b1; tick(); ser_in = 1'b0; tick();
    mode = 2'b00; tick();
    field_and_check(1'b0, "R9 arm discarded");
    mode = 2'b01; tick();
    field_and_check(1'b0, "R9 still disarmed");

    // R7 R8 random edges and field strobes against a model
    begin
      bit armed = 1'b0;
      bit prev  = ser_in;
      for (int c = 0; c < 400; c++) begin
        bit rise;
        bit exp_p;
        ser_in      = ($urandom % 3) == 0;
        field_start = ($urandom % 6) == 0;
        rise  = ser_in && !prev;
        exp_p = field_start && armed;
        if (exp_p) armed = 1'b0;
        else if (rise) armed = 1'b1;
        prev = ser_in;
        tick();
        check(phase_rst == exp_p, "R8 random arm/fire", 32'(phase_rst), 32'(exp_p));
      end
      field_start = 1'b0; ser_in = 1'b0;
    end
    tick();
    finish_run();
  end
endmodule